// File: doc/BRIEF.md
# Serial Controller Auto-Read Engine

This block collects button state from two serial game controllers without help from software. Each port has two active-low data lines, so four 16-bit button words are gathered at once. A one-cycle start pulse from the frame-timing logic begins a sequence, but only if automatic reading is enabled. The engine raises the shared latch strobe for one bit period. It then gives each port sixteen clock pulses and samples all four lines in the low half of every bit period. When the sequence ends, all four results are updated in the same cycle.

Software can also drive the latch line by hand and read each port's two lines directly. A busy output stays high from the cycle after an accepted start until the results are committed.

Top module: `pad_autoread`

## Requirements
- R1: While reset is held and just after it is released, `busy_o`, `pclk_o` and `result_o` are zero, and `latch_o` equals `manual_latch_i`.
- R2: Whenever `manual_latch_i` is 1, `latch_o` is 1, in any state.
- R3: Bits 1:0 of each port's byte in `port_rd_o` hold that port's two lines inverted, so a low line reads 1. Port p occupies bits p*8+7:p*8. Line l of port p is `ser_line_i[p*2+l]`. Port 0's bits 7:2 and port 1's bits 7:5 are 0.
- R4: Bits 4:2 of port 1's byte in `port_rd_o` always read 1.
- R5: A start pulse that is sampled while `auto_en_i` is 1 and the block is idle raises `busy_o` at the next edge. `latch_o` is then high for exactly BIT_CYC cycles, with no port clock pulse.
- R6: A start pulse sampled while `auto_en_i` is 0 has no effect: `busy_o` stays 0 and the results keep their value.
- R7: After the latch, each port receives exactly 16 clock pulses, one every BIT_CYC cycles. Each pulse is high for the second half of its bit period. `pclk_o` is 0 whenever the block is not busy.
- R8: Result lane j (bits j*16+15:j*16) comes from `ser_line_i[j]` and is stored inverted, so a low line reads 1. The first bit sampled ends up in bit 15 and the last bit sampled in bit 0.
- R9: `result_o` changes only at the edge where `busy_o` falls. All four lanes update together.
- R10: A start pulse sampled while `busy_o` is 1, including the final busy cycle, is ignored. The running sequence keeps its length, and no new sequence follows.
- R11: Once a start is accepted, `busy_o` stays high for exactly 17*BIT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame start pulse, one cycle |
| auto_en_i | input | 1 | Automatic read enable |
| manual_latch_i | input | 1 | Software-driven latch level |
| ser_line_i | input | NPORTS*LINES | Controller data lines, active low |
| latch_o | output | 1 | Latch strobe to both controllers |
| pclk_o | output | NPORTS | Per-port serial clock |
| busy_o | output | 1 | Automatic read in progress |
| port_rd_o | output | NPORTS*8 | Direct port read bytes |
| result_o | output | NPORTS*LINES*RES_W | Four button words, lane 0 lowest |

## Verification
Two events can share a cycle: a new start request and the commit that ends the current sequence. Busy is still high in that cycle.

The bench provokes this by counting cycles from an accepted start and raising the start pulse exactly in the last busy cycle. The scoreboard confirms that the results match the words loaded into the controller models. A correct result is this: `busy_o` falls on schedule and stays low, and no second set of results is produced.

// File: rtl/pad_ar_pkg.sv
package pad_ar_pkg;
   typedef enum logic [1:0] {
      AR_IDLE  = 2'd0,
      AR_LATCH = 2'd1,
      AR_SHIFT = 2'd2
   } ar_state_e;

   localparam int PORT_BYTE_W = 8;
   localparam int FILL_PORT   = 1;
   localparam int FILL_LO     = 2;
   localparam int FILL_HI     = 4;
endpackage

// File: rtl/pad_ar_seq.sv
module pad_ar_seq
   import pad_ar_pkg::*;
#(
   parameter int BIT_CYC = 4,
   parameter int NBITS   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic auto_en_i,
   output logic busy_o,
   output logic auto_latch_o,
   output logic pclk_o,
   output logic sample_o,
   output logic commit_o
);
   localparam int CYC_W = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
   localparam int BIT_W = $clog2(NBITS);
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(BIT_CYC - 1);
   localparam logic [CYC_W-1:0] CYC_HALF = CYC_W'(BIT_CYC / 2);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NBITS - 1);

   initial begin
      assert (BIT_CYC >= 2 && (BIT_CYC % 2) == 0)
         else $fatal(1, "BIT_CYC must be even and at least 2");
      assert (NBITS >= 2) else $fatal(1, "NBITS must be at least 2");
   end

   ar_state_e        state_q;
   logic [CYC_W-1:0] cyc_q;
   logic [BIT_W-1:0] bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= AR_IDLE;
         cyc_q   <= '0;
         bit_q   <= '0;
      end else begin
         unique case (state_q)
            AR_IDLE: begin
               if (start_i && auto_en_i) begin
                  state_q <= AR_LATCH;
                  cyc_q   <= '0;
               end
            end
            AR_LATCH: begin
               if (cyc_q == CYC_LAST) begin
                  state_q <= AR_SHIFT;
                  cyc_q   <= '0;
                  bit_q   <= '0;
               end else begin
                  cyc_q <= cyc_q + 1'b1;
               end
            end
            AR_SHIFT: begin
               if (cyc_q == CYC_LAST) begin
                  cyc_q <= '0;
                  if (bit_q == BIT_LAST) state_q <= AR_IDLE;
                  else                   bit_q   <= bit_q + 1'b1;
               end else begin
                  cyc_q <= cyc_q + 1'b1;
               end
            end
            default: state_q <= AR_IDLE;
         endcase
      end
   end

   always_comb begin
      busy_o       = (state_q != AR_IDLE);
      auto_latch_o = (state_q == AR_LATCH);
      pclk_o       = (state_q == AR_SHIFT) && (cyc_q >= CYC_HALF);
      sample_o     = (state_q == AR_SHIFT) && (cyc_q == '0);
      commit_o     = (state_q == AR_SHIFT) && (cyc_q == CYC_LAST) && (bit_q == BIT_LAST);
   end
endmodule

// File: rtl/pad_ar_lane.sv
module pad_ar_lane #(
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_i,
   input  logic             sample_i,
   input  logic             commit_i,
   output logic [RES_W-1:0] result_o
);
   logic [RES_W-1:0] shift_q;
   logic [RES_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         hold_q  <= '0;
      end else begin
         if (sample_i) shift_q <= {shift_q[RES_W-2:0], bit_i};
         if (commit_i) hold_q  <= shift_q;
      end
   end

   assign result_o = hold_q;
endmodule

// File: rtl/pad_ar_direct.sv
module pad_ar_direct
   import pad_ar_pkg::*;
#(
   parameter int NPORTS = 2,
   parameter int LINES  = 2
) (
   input  logic [NPORTS*LINES-1:0]       lv_i,
   output logic [NPORTS*PORT_BYTE_W-1:0] rd_o
);
   initial begin
      assert (LINES <= FILL_LO) else $fatal(1, "data lines overlap the fixed bits");
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [PORT_BYTE_W-1:0] byte_c;
      always_comb begin
         byte_c            = '0;
         byte_c[LINES-1:0] = lv_i[p*LINES +: LINES];
         if (p == FILL_PORT) byte_c[FILL_HI:FILL_LO] = '1;
      end
      assign rd_o[p*PORT_BYTE_W +: PORT_BYTE_W] = byte_c;
   end
endmodule

// File: rtl/pad_autoread.sv
module pad_autoread
   import pad_ar_pkg::*;
#(
   parameter int NPORTS     = 2,
   parameter int LINES      = 2,
   parameter int RES_W      = 16,
   parameter int BIT_CYC    = 4,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          auto_en_i,
   input  logic                          manual_latch_i,
   input  logic [NPORTS*LINES-1:0]       ser_line_i,
   output logic                          latch_o,
   output logic [NPORTS-1:0]             pclk_o,
   output logic                          busy_o,
   output logic [NPORTS*PORT_BYTE_W-1:0] port_rd_o,
   output logic [NPORTS*LINES*RES_W-1:0] result_o
);
   localparam int NLANES = NPORTS * LINES;

   initial begin
      assert (NPORTS == 2) else $fatal(1, "NPORTS must be 2");
      assert (LINES >= 1)  else $fatal(1, "LINES must be at least 1");
   end

   logic [NLANES-1:0] lv;
   logic auto_latch, pclk, sample, commit;

   if (ACTIVE_LOW) begin : g_pol_low
      assign lv = ~ser_line_i;
   end else begin : g_pol_high
      assign lv = ser_line_i;
   end

   pad_ar_seq #(.BIT_CYC(BIT_CYC), .NBITS(RES_W)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .auto_en_i    (auto_en_i),
      .busy_o       (busy_o),
      .auto_latch_o (auto_latch),
      .pclk_o       (pclk),
      .sample_o     (sample),
      .commit_o     (commit)
   );

   for (genvar j = 0; j < NLANES; j++) begin : g_lane
      pad_ar_lane #(.RES_W(RES_W)) i_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .bit_i    (lv[j]),
         .sample_i (sample),
         .commit_i (commit),
         .result_o (result_o[j*RES_W +: RES_W])
      );
   end

   pad_ar_direct #(.NPORTS(NPORTS), .LINES(LINES)) i_direct (
      .lv_i (lv),
      .rd_o (port_rd_o)
   );

   assign latch_o = auto_latch | manual_latch_i;
   assign pclk_o  = {NPORTS{pclk}};
endmodule

// File: rtl/pad_autoread_chk.sv
module pad_autoread_chk #(
   parameter int NPORTS  = 2,
   parameter int RW      = 64,
   parameter int BIT_CYC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              auto_en_i,
   input logic              manual_latch_i,
   input logic              latch_o,
   input logic [NPORTS-1:0] pclk_o,
   input logic              busy_o,
   input logic [2:0]        fill_i,
   input logic [RW-1:0]     result_o
);
   localparam int SEQ_LEN = 17 * BIT_CYC;

   logic [31:0] busy_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      busy_cnt_q <= '0;
      else if (busy_o) busy_cnt_q <= busy_cnt_q + 1;
      else             busy_cnt_q <= '0;
   end

   a_r2_manual_latch: assert property (@(posedge clk) disable iff (!rst_n)
      manual_latch_i |-> latch_o);

   a_r4_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
      fill_i == 3'b111);

   a_r5_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && auto_en_i && !busy_o) |=> (busy_o && latch_o && (pclk_o == '0)));

   a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !auto_en_i) |=> !busy_o);

   a_r7_pclk_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (pclk_o != '0) |-> busy_o);

   a_r9_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> $fell(busy_o));

   a_r11_seq_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_cnt_q == SEQ_LEN));
endmodule

bind pad_autoread pad_autoread_chk #(
   .NPORTS  (NPORTS),
   .RW      (NPORTS*LINES*RES_W),
   .BIT_CYC (BIT_CYC)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start_i        (start_i),
   .auto_en_i      (auto_en_i),
   .manual_latch_i (manual_latch_i),
   .latch_o        (latch_o),
   .pclk_o         (pclk_o),
   .busy_o         (busy_o),
   .fill_i         (port_rd_o[12:10]),
   .result_o       (result_o)
);

// File: tb/test_pad_autoread.sv
module test_pad_autoread;
   localparam int BIT_CYC = 4;
   localparam int NL      = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        auto_en_i = 1'b0;
   logic        manual_latch_i = 1'b0;
   logic [3:0]  ser_line_i;
   logic        latch_o;
   logic [1:0]  pclk_o;
   logic        busy_o;
   logic [15:0] port_rd_o;
   logic [63:0] result_o;

   always #5 clk = ~clk;

   pad_autoread i_pad_autoread (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
      .manual_latch_i(manual_latch_i), .ser_line_i(ser_line_i),
      .latch_o(latch_o), .pclk_o(pclk_o), .busy_o(busy_o),
      .port_rd_o(port_rd_o), .result_o(result_o)
   );

   // controller models: pressed word -> active-low shift register
   logic [15:0] btn [NL];
   logic [15:0] sr  [NL];
   logic [1:0]  pclk_d;
   logic        use_model = 1'b1;
   logic [3:0]  man_lines = 4'hF;
   logic [3:0]  model_lines;

   always @(posedge clk) begin
      for (int j = 0; j < NL; j++) begin
         if (latch_o) sr[j] <= ~btn[j];
         else if (pclk_o[j/2] && !pclk_d[j/2]) sr[j] <= {sr[j][14:0], 1'b1};
      end
      pclk_d <= pclk_o;
   end

   always_comb for (int j = 0; j < NL; j++) model_lines[j] = sr[j][15];
   assign ser_line_i = use_model ? model_lines : man_lines;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard
   logic [63:0] exp_q[$];
   logic [63:0] held_res = '0;
   logic        prev_busy = 1'b0;
   logic        prev_pclk = 1'b0;
   int busy_len = 0, pulses = 0, latch_len = 0;
   bit r9_bad = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy_o) begin
            busy_len++;
            if (pclk_o[0] && !prev_pclk) pulses++;
            if (latch_o && !manual_latch_i) latch_len++;
            if (result_o !== held_res) r9_bad = 1'b1;
         end
         if (prev_busy && !busy_o) begin
            if (exp_q.size() == 0) chk("R10 unexpected sequence", 64'd1, 64'd0);
            else chk("R8 results", result_o, exp_q.pop_front());
            chk("R7 pulse count", 64'(pulses), 64'd16);
            chk("R11 busy length", 64'(busy_len), 64'(17*BIT_CYC));
            chk("R5 latch length", 64'(latch_len), 64'(BIT_CYC));
            chk("R9 hold while busy", 64'(r9_bad), 64'd0);
            held_res  = result_o;
            busy_len  = 0; pulses = 0; latch_len = 0; r9_bad = 1'b0;
         end
         prev_busy = busy_o;
         prev_pclk = pclk_o[0];
      end
   end

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic drive_seq(input logic [15:0] b0, b1, b2, b3);
      btn[0] = b0; btn[1] = b1; btn[2] = b2; btn[3] = b3;
      exp_q.push_back({b3, b2, b1, b0});
      pulse_start();
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int j = 0; j < NL; j++) begin btn[j] = '0; sr[j] = '1; end
      pclk_d = '0;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 64'(busy_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", 64'(busy_o), 64'd0);
      chk("R1 latch", 64'(latch_o), 64'd0);
      chk("R1 pclk", 64'(pclk_o), 64'd0);
      chk("R1 results", result_o, 64'd0);

      // R2 manual latch
      manual_latch_i = 1'b1; #1;
      chk("R2 latch follows manual", 64'(latch_o), 64'd1);
      @(negedge clk) manual_latch_i = 1'b0; #1;
      chk("R2 latch released", 64'(latch_o), 64'd0);

      // R3 / R4 direct read
      use_model = 1'b0;
      man_lines = 4'b1010; #1;
      chk("R3 port0 direct", 64'(port_rd_o[7:0]), 64'h01);
      chk("R4 port1 direct", 64'(port_rd_o[15:8]), 64'h1D);
      man_lines = 4'b0101; #1;
      chk("R3 port0 direct", 64'(port_rd_o[7:0]), 64'h02);
      chk("R4 port1 direct", 64'(port_rd_o[15:8]), 64'h1E);
      use_model = 1'b1;

      // R6 start while disabled
      auto_en_i = 1'b0;
      pulse_start();
      repeat (10) @(negedge clk);
      chk("R6 no sequence when disabled", 64'(busy_o), 64'd0);
      chk("R6 results kept", result_o, 64'd0);

      auto_en_i = 1'b1;
      drive_seq(16'h8001, 16'hA5C3, 16'hFFFF, 16'h0000);
      wait_idle();
      drive_seq(16'h1234, 16'h0F0F, 16'h7FFE, 16'hC003);
      wait_idle();

      // R10 start in middle of sequence
      drive_seq(16'h0001, 16'h8000, 16'h5555, 16'hAAAA);
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      wait_idle();
      repeat (5) @(negedge clk);
      chk("R10 mid-sequence start ignored", 64'(busy_o), 64'd0);

      // R10 start in final busy cycle
      drive_seq(16'hDEAD, 16'hBEEF, 16'h00FF, 16'hFF00);
      repeat (67) @(negedge clk);
      chk("R10 still busy in last cycle", 64'(busy_o), 64'd1);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      chk("R10 busy fell on schedule", 64'(busy_o), 64'd0);
      repeat (4) @(negedge clk);
      chk("R10 final-cycle start ignored", 64'(busy_o), 64'd0);
      chk("R10 scoreboard drained", 64'(exp_q.size()), 64'd0);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule